// File: doc/BRIEF.md
# Receive PCS State Machine with Rate-Matcher Slip Absorption

This block is the receive-side coding-layer state machine of a 1000BASE-X gigabit Ethernet port. It consumes one decoded code group per clock from a transceiver. Along with each code group come a control flag, a code-violation flag and an even/odd position flag. A sync status, the transmit-mode setting and two flags from the elastic buffer come in as well; the buffer flags mark code groups that the buffer inserted or deleted. From this stream it recovers the packet-framing outputs `receiving`, `rxDv`, `rxEr` and `rxd`. It also assembles the 16-bit configuration word carried by configuration ordered sets, and gives one-cycle indications of a configuration set, an idle set, or an invalid stream seen during configuration.

During auto-negotiation the elastic buffer compensates clock offset by duplicating or dropping the leading comma/tag pair of a configuration ordered set. A plain receive machine reads such a slip as a framing error and falls into its invalid state, which can restart negotiation. This machine adds priority-ordered exits from the tag, second-data and idle-data states. These exits follow the buffer flags, so a duplicated pair is skipped and a missing pair is bridged.

All outputs are registered. The outputs caused by a code group show up right after the clock edge at which that code group is sampled.

Top module: `gbe_rx_pcs`

## Requirements
- R1: While `rstN` is low, `receiving`, `rxDv`, `rxEr`, all three indications, `rxd` and `cfgReg` are zero.
- R2: A cycle with `syncOk` low clears `receiving`, `rxDv` and `rxEr` after that edge. After sync returns, every code group is ignored until a K28.5 (0xBC with the control flag) arrives on an even position (`cgEven`=1). Only then does configuration capture resume.
- R3: A K28.5 on an even position, then 0xB5 or 0x42 as data, then data bytes B1 and B2 loads `cfgReg` = {B2,B1}. `rudiCfg` pulses for exactly the cycle after B2.
- R4: In the tag state, a code group without the violation flag, with `rmIns`=1 and `rmDel`=0, keeps the machine in the tag state with no capture. This holds even for a K28.5. With both flags high this path does not apply.
- R5: In the tag state, without an insertion, a control code group or a flagged code group leads to the invalid state. If `xmitMode` is 2'b00 (configuration), this gives a single `rudiBad` pulse.
- R6: In the second-data state, a clean data code group with `rmDel`=1 and `rmIns`=0 is taken as the first configuration byte of a new word. The next data byte then completes it. With both flags high the group is invalid.
- R7: In the second-data state, anything other than that deletion case or an even K28.5 leads to the invalid state.
- R8: In the idle-data state, a clean data code group with `rmDel`=1, `rmIns`=0 and `cgEven`=1 is taken as a first configuration byte. On an odd position the same group is invalid when `xmitMode` is not DATA.
- R9: In the idle-data state with `xmitMode` not 2'b10 (DATA), any code group other than K28.5 enters the invalid state, which pulses `rudiBad` once on entry. The invalid state is left only on an even K28.5.
- R10: After a comma, 0xB5 or 0x42 leads to configuration capture. Any other clean data byte leads to the idle-data state and a one-cycle `rudiIdle` pulse.
- R11: With `xmitMode` DATA, a code group in the idle-data state that is neither K28.5 nor start-of-packet (0xFB with the control flag) is a false carrier. It sets `receiving`, sets `rxEr`, and drives `rxd` to 0x0E until the next even K28.5.
- R12: Entering the invalid state with `xmitMode` DATA sets `receiving` and gives no `rudiBad`.
- R13: Start-of-packet sets `receiving` and `rxDv` with `rxd`=0x55. Clean data bytes are forwarded on `rxd` with `rxDv` high. A flagged byte raises `rxEr` and leaves `rxd` unchanged. End-of-packet (0xFD with the control flag) clears `receiving`, `rxDv` and `rxEr`. `rxDv` is never high without `receiving`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, one code group per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| cgData | input | 8 | Decoded code-group byte |
| cgIsK | input | 1 | Code group is a control character |
| cgBad | input | 1 | Code violation or disparity error |
| cgEven | input | 1 | Code group sits on an even position |
| syncOk | input | 1 | Word synchronization is held |
| xmitMode | input | 2 | 00 configuration, 01 idle, 10 data |
| rmIns | input | 1 | Elastic buffer inserted this code group |
| rmDel | input | 1 | Elastic buffer deleted code groups just before this one |
| receiving | output | 1 | Carrier event in progress |
| rxDv | output | 1 | Received data valid |
| rxEr | output | 1 | Received error |
| rxd | output | 8 | Received data byte |
| cfgReg | output | 16 | Last captured configuration word |
| rudiCfg | output | 1 | One-cycle pulse per completed configuration set |
| rudiIdle | output | 1 | One-cycle pulse per idle set |
| rudiBad | output | 1 | One-cycle pulse on entry to invalid during configuration |

## Verification
The insert and delete flags can both be high in the same cycle. This is the point where the slip-absorbing exits and the standard exits compete. The bench raises both flags together in the tag state with a comma, and in the second-data state with a clean data byte. In both cases the absorption must give way, and the machine must fall into the invalid state with a `rudiBad` pulse. The captured word must stay unchanged. A deletion on an odd position in the idle-data state is driven as well, and must also fall through to the invalid state. The normal single-flag slips are then replayed in a continuous stream to show that each is absorbed.

// File: rtl/gbe_rx_pcs_pkg.sv
`timescale 1ns/1ps
package gbe_rx_pcs_pkg;

  localparam int CODE_W = 8;
  localparam int CFG_W  = 2 * CODE_W;

  localparam logic [CODE_W-1:0] CG_COMMA   = 8'hBC; // K28.5
  localparam logic [CODE_W-1:0] CG_TAG_A   = 8'hB5; // D21.5
  localparam logic [CODE_W-1:0] CG_TAG_B   = 8'h42; // D2.2
  localparam logic [CODE_W-1:0] CG_START   = 8'hFB; // K27.7
  localparam logic [CODE_W-1:0] CG_TERM    = 8'hFD; // K29.7
  localparam logic [CODE_W-1:0] RXD_PREAMB = 8'h55;
  localparam logic [CODE_W-1:0] RXD_FCAR   = 8'h0E;

  localparam logic [1:0] XM_CONFIG = 2'b00;
  localparam logic [1:0] XM_IDLE   = 2'b01;
  localparam logic [1:0] XM_DATA   = 2'b10;

  typedef enum logic [3:0] {
    ST_LINK_DOWN, ST_HUNT_K, ST_COMMA, ST_TAG, ST_CFG_LO, ST_CFG_HI,
    ST_IDLE_D, ST_INVALID, ST_SOP, ST_PAYLOAD, ST_EOP, ST_FALSE_CAR
  } pcsStateT;

  typedef struct packed {
    logic clrAll;
    logic capLo;
    logic capHi;
    logic idleSeen;
    logic badCfg;
    logic badData;
    logic sop;
    logic dataOk;
    logic dataErr;
    logic falseCar;
    logic eop;
  } strobeT;

endpackage

// File: rtl/gbe_rx_pcs_ctrl.sv
`timescale 1ns/1ps
module gbe_rx_pcs_ctrl
  import gbe_rx_pcs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] cgData,
  input  logic              cgIsK,
  input  logic              cgBad,
  input  logic              cgEven,
  input  logic              syncOk,
  input  logic [1:0]        xmitMode,
  input  logic              rmIns,
  input  logic              rmDel,
  output strobeT            stb
);

  pcsStateT stateQ, stateNxt;

  logic isData, isComma, evenComma, cfgTag, isStart, isTerm;
  logic insOnly, delOnly, inData;

  always_comb begin
    isData    = !cgIsK && !cgBad;
    isComma   = cgIsK && !cgBad && (cgData == CG_COMMA);
    evenComma = isComma && cgEven;
    cfgTag    = isData && ((cgData == CG_TAG_A) || (cgData == CG_TAG_B));
    isStart   = cgIsK && !cgBad && (cgData == CG_START);
    isTerm    = cgIsK && !cgBad && (cgData == CG_TERM);
    insOnly   = rmIns && !rmDel;
    delOnly   = rmDel && !rmIns;
    inData    = (xmitMode == XM_DATA);
  end

  always_comb begin
    stateNxt = stateQ;
    if (!syncOk) begin
      stateNxt = ST_LINK_DOWN;
    end else begin
      unique case (stateQ)
        ST_LINK_DOWN: stateNxt = ST_HUNT_K;
        ST_HUNT_K, ST_INVALID, ST_EOP, ST_FALSE_CAR:
          if (evenComma) stateNxt = ST_COMMA;
        ST_COMMA: begin
          if (cfgTag)                 stateNxt = ST_TAG;
          else if (isData || inData)  stateNxt = ST_IDLE_D;
          else                        stateNxt = ST_INVALID;
        end
        ST_TAG: begin
          if (!cgBad && insOnly)      stateNxt = ST_TAG;
          else if (cgIsK || cgBad)    stateNxt = ST_INVALID;
          else                        stateNxt = ST_CFG_LO;
        end
        ST_CFG_LO: stateNxt = isData ? ST_CFG_HI : ST_INVALID;
        ST_CFG_HI: begin
          if (isData && delOnly)      stateNxt = ST_CFG_LO;
          else if (evenComma)         stateNxt = ST_COMMA;
          else                        stateNxt = ST_INVALID;
        end
        ST_IDLE_D: begin
          if (isData && delOnly && cgEven) stateNxt = ST_CFG_LO;
          else if (isComma)                stateNxt = ST_COMMA;
          else if (!inData)                stateNxt = ST_INVALID;
          else if (isStart)                stateNxt = ST_SOP;
          else                             stateNxt = ST_FALSE_CAR;
        end
        ST_SOP, ST_PAYLOAD: begin
          if (isData)                 stateNxt = ST_PAYLOAD;
          else if (isTerm)            stateNxt = ST_EOP;
          else if (evenComma)         stateNxt = ST_COMMA;
          else                        stateNxt = ST_PAYLOAD;
        end
        default: stateNxt = ST_LINK_DOWN;
      endcase
    end
  end

  always_comb begin
    stb          = '0;
    stb.clrAll   = (stateNxt == ST_LINK_DOWN) || (stateNxt == ST_COMMA);
    stb.capLo    = (stateNxt == ST_CFG_LO);
    stb.capHi    = (stateNxt == ST_CFG_HI);
    stb.idleSeen = (stateNxt == ST_IDLE_D);
    stb.badCfg   = (stateNxt == ST_INVALID) && (stateQ != ST_INVALID) && (xmitMode == XM_CONFIG);
    stb.badData  = (stateNxt == ST_INVALID) && (stateQ != ST_INVALID) && inData;
    stb.sop      = (stateNxt == ST_SOP);
    stb.dataOk   = (stateNxt == ST_PAYLOAD) && isData;
    stb.dataErr  = (stateNxt == ST_PAYLOAD) && !isData;
    stb.falseCar = (stateNxt == ST_FALSE_CAR) && (stateQ != ST_FALSE_CAR);
    stb.eop      = (stateNxt == ST_EOP) && (stateQ != ST_EOP);
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_LINK_DOWN;
    else       stateQ <= stateNxt;
  end

  // R2
  sync_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !syncOk |=> (stateQ == ST_LINK_DOWN));

  // R4
  ins_absorb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncOk && stateQ == ST_TAG && !cgBad && rmIns && !rmDel) |=> (stateQ == ST_TAG));

  // R6
  del_bridge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncOk && stateQ == ST_CFG_HI && !cgIsK && !cgBad && rmDel && !rmIns) |=> (stateQ == ST_CFG_LO));

  // R8
  idle_del_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncOk && stateQ == ST_IDLE_D && !cgIsK && !cgBad && rmDel && !rmIns && cgEven)
      |=> (stateQ == ST_CFG_LO));

endmodule

// File: rtl/gbe_rx_pcs_dp.sv
`timescale 1ns/1ps
module gbe_rx_pcs_dp
  import gbe_rx_pcs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] cgData,
  input  strobeT            stb,
  output logic              receiving,
  output logic              rxDv,
  output logic              rxEr,
  output logic [CODE_W-1:0] rxd,
  output logic [CFG_W-1:0]  cfgReg,
  output logic              rudiCfg,
  output logic              rudiIdle,
  output logic              rudiBad
);

  logic [CODE_W-1:0] cfgLoQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      receiving <= 1'b0;
      rxDv      <= 1'b0;
      rxEr      <= 1'b0;
      rxd       <= '0;
      cfgLoQ    <= '0;
      cfgReg    <= '0;
      rudiCfg   <= 1'b0;
      rudiIdle  <= 1'b0;
      rudiBad   <= 1'b0;
    end else begin
      rudiCfg  <= stb.capHi;
      rudiIdle <= stb.idleSeen;
      rudiBad  <= stb.badCfg;
      if (stb.clrAll || stb.eop) begin
        receiving <= 1'b0;
        rxDv      <= 1'b0;
        rxEr      <= 1'b0;
      end
      if (stb.capLo) cfgLoQ <= cgData;
      if (stb.capHi) cfgReg <= {cgData, cfgLoQ};
      if (stb.badData) receiving <= 1'b1;
      if (stb.sop) begin
        receiving <= 1'b1;
        rxDv      <= 1'b1;
        rxEr      <= 1'b0;
        rxd       <= RXD_PREAMB;
      end
      if (stb.dataOk) begin
        rxDv <= 1'b1;
        rxEr <= 1'b0;
        rxd  <= cgData;
      end
      if (stb.dataErr) rxEr <= 1'b1;
      if (stb.falseCar) begin
        receiving <= 1'b1;
        rxEr      <= 1'b1;
        rxDv      <= 1'b0;
        rxd       <= RXD_FCAR;
      end
    end
  end

  // R13
  dv_needs_recv_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDv |-> receiving);

  // R11
  false_car_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.falseCar |=> (rxEr && receiving && rxd == RXD_FCAR));

  // R3
  single_rudi_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rudiCfg, rudiIdle, rudiBad}));

  // R3
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capHi |=> rudiCfg && (cfgReg[CFG_W-1:CODE_W] == $past(cgData)));

endmodule

// File: rtl/gbe_rx_pcs.sv
`timescale 1ns/1ps
module gbe_rx_pcs
  import gbe_rx_pcs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] cgData,
  input  logic              cgIsK,
  input  logic              cgBad,
  input  logic              cgEven,
  input  logic              syncOk,
  input  logic [1:0]        xmitMode,
  input  logic              rmIns,
  input  logic              rmDel,
  output logic              receiving,
  output logic              rxDv,
  output logic              rxEr,
  output logic [CODE_W-1:0] rxd,
  output logic [CFG_W-1:0]  cfgReg,
  output logic              rudiCfg,
  output logic              rudiIdle,
  output logic              rudiBad
);

  strobeT stb;

  gbe_rx_pcs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cgData(cgData), .cgIsK(cgIsK), .cgBad(cgBad),
    .cgEven(cgEven), .syncOk(syncOk), .xmitMode(xmitMode), .rmIns(rmIns),
    .rmDel(rmDel), .stb(stb)
  );

  gbe_rx_pcs_dp u_dp (
    .clk(clk), .rstN(rstN), .cgData(cgData), .stb(stb),
    .receiving(receiving), .rxDv(rxDv), .rxEr(rxEr), .rxd(rxd),
    .cfgReg(cfgReg), .rudiCfg(rudiCfg), .rudiIdle(rudiIdle), .rudiBad(rudiBad)
  );

endmodule

// File: tb/sim_gbe_rx_pcs.sv
`timescale 1ns/1ps
module sim_gbe_rx_pcs;

  localparam logic L = 1'b0;
  localparam logic H = 1'b1;
  localparam logic [1:0] CF = 2'b00;
  localparam logic [1:0] DT = 2'b10;

  typedef struct packed {
    logic [7:0]  d;
    logic        k, bad, ev, sy;
    logic [1:0]  xm;
    logic        ins, del;
    logic [5:0]  eFlags;   // receiving, rxDv, rxEr, rudiCfg, rudiIdle, rudiBad
    logic [15:0] eCfg;
    logic [3:0]  req;
  } vecT;

  localparam int NV = 50;
  localparam vecT TBL [NV] = '{
    '{8'hBC,H,L,H,H,CF,L,L,6'b000000,16'h0000,4'd2},  // R2 leave link-down
    '{8'hBC,H,L,H,H,CF,L,L,6'b000000,16'h0000,4'd2},
    '{8'hB5,L,L,L,H,CF,L,L,6'b000000,16'h0000,4'd10},
    '{8'h34,L,L,H,H,CF,L,L,6'b000000,16'h0000,4'd3},
    '{8'h12,L,L,L,H,CF,L,L,6'b000100,16'h1234,4'd3},  // R3
    '{8'hBC,H,L,H,H,CF,L,L,6'b000000,16'h1234,4'd3},
    '{8'h42,L,L,L,H,CF,L,L,6'b000000,16'h1234,4'd10},
    '{8'hBC,H,L,H,H,CF,H,L,6'b000000,16'h1234,4'd4},  // R4 inserted pair
    '{8'h42,L,L,L,H,CF,H,L,6'b000000,16'h1234,4'd4},
    '{8'h78,L,L,H,H,CF,L,L,6'b000000,16'h1234,4'd4},
    '{8'h56,L,L,L,H,CF,L,L,6'b000100,16'h5678,4'd4},
    '{8'hBC,H,L,H,H,CF,L,L,6'b000000,16'h5678,4'd3},
    '{8'hB5,L,L,L,H,CF,L,L,6'b000000,16'h5678,4'd3},
    '{8'hCD,L,L,H,H,CF,L,L,6'b000000,16'h5678,4'd3},
    '{8'hAB,L,L,L,H,CF,L,L,6'b000100,16'hABCD,4'd3},
    '{8'h11,L,L,H,H,CF,L,H,6'b000000,16'hABCD,4'd6},  // R6 deleted pair
    '{8'h22,L,L,L,H,CF,L,H,6'b000100,16'h2211,4'd6},
    '{8'hBC,H,L,H,H,CF,L,L,6'b000000,16'h2211,4'd6},
    '{8'h50,L,L,L,H,CF,L,L,6'b000010,16'h2211,4'd10}, // R10 idle
    '{8'h99,L,L,H,H,CF,L,H,6'b000000,16'h2211,4'd8},  // R8 deletion after idle
    '{8'h88,L,L,L,H,CF,L,H,6'b000100,16'h8899,4'd8},
    '{8'hBC,H,L,H,H,CF,L,L,6'b000000,16'h8899,4'd8},
    '{8'h50,L,L,L,H,CF,L,L,6'b000010,16'h8899,4'd10},
    '{8'hBC,H,L,H,H,CF,L,L,6'b000000,16'h8899,4'd9},
    '{8'h50,L,L,L,H,CF,L,L,6'b000010,16'h8899,4'd10},
    '{8'h33,L,L,H,H,CF,L,L,6'b000001,16'h8899,4'd9},  // R9 non-comma in idle
    '{8'h33,L,L,L,H,CF,L,L,6'b000000,16'h8899,4'd9},
    '{8'hBC,H,L,L,H,CF,L,L,6'b000000,16'h8899,4'd9},  // odd comma keeps invalid
    '{8'hBC,H,L,H,H,CF,L,L,6'b000000,16'h8899,4'd9},
    '{8'hB5,L,L,L,H,CF,L,L,6'b000000,16'h8899,4'd10},
    '{8'hBC,H,L,H,H,CF,L,L,6'b000001,16'h8899,4'd5},  // R5 comma in tag slot
    '{8'hBC,H,L,H,H,CF,L,L,6'b000000,16'h8899,4'd5},
    '{8'h42,L,L,L,H,CF,L,L,6'b000000,16'h8899,4'd3},
    '{8'h01,L,L,H,H,CF,L,L,6'b000000,16'h8899,4'd3},
    '{8'h02,L,L,L,H,CF,L,L,6'b000100,16'h0201,4'd3},
    '{8'h44,L,L,H,H,CF,L,L,6'b000001,16'h0201,4'd7},  // R7 data where comma due
    '{8'hBC,H,L,H,H,CF,L,L,6'b000000,16'h0201,4'd7},
    '{8'h50,L,L,L,H,DT,L,L,6'b000010,16'h0201,4'd10},
    '{8'hFB,H,L,H,H,DT,L,L,6'b110000,16'h0201,4'd13}, // R13 start
    '{8'hA1,L,L,L,H,DT,L,L,6'b110000,16'h0201,4'd13},
    '{8'hFD,H,L,H,H,DT,L,L,6'b000000,16'h0201,4'd13},
    '{8'hF7,H,L,L,H,DT,L,L,6'b000000,16'h0201,4'd13},
    '{8'hBC,H,L,H,H,DT,L,L,6'b000000,16'h0201,4'd13},
    '{8'h50,L,L,L,H,DT,L,L,6'b000010,16'h0201,4'd10},
    '{8'h23,L,L,H,H,DT,L,L,6'b101000,16'h0201,4'd11}, // R11 false carrier
    '{8'h23,L,L,L,H,DT,L,L,6'b101000,16'h0201,4'd11},
    '{8'hBC,H,L,H,H,DT,L,L,6'b000000,16'h0201,4'd11},
    '{8'hB5,L,L,L,H,DT,L,L,6'b000000,16'h0201,4'd10},
    '{8'h1C,H,L,H,H,DT,L,L,6'b100000,16'h0201,4'd12}, // R12 invalid in data
    '{8'hBC,H,L,H,H,DT,L,L,6'b000000,16'h0201,4'd12}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] cgData = '0;
  logic cgIsK = 1'b0, cgBad = 1'b0, cgEven = 1'b0, syncOk = 1'b0;
  logic [1:0] xmitMode = 2'b00;
  logic rmIns = 1'b0, rmDel = 1'b0;
  logic receiving, rxDv, rxEr, rudiCfg, rudiIdle, rudiBad;
  logic [7:0] rxd;
  logic [15:0] cfgReg;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gbe_rx_pcs u0 (
    .clk(clk), .rstN(rstN), .cgData(cgData), .cgIsK(cgIsK), .cgBad(cgBad),
    .cgEven(cgEven), .syncOk(syncOk), .xmitMode(xmitMode), .rmIns(rmIns),
    .rmDel(rmDel), .receiving(receiving), .rxDv(rxDv), .rxEr(rxEr), .rxd(rxd),
    .cfgReg(cfgReg), .rudiCfg(rudiCfg), .rudiIdle(rudiIdle), .rudiBad(rudiBad)
  );

  task automatic drv(input logic [7:0] d, input logic k, input logic b, input logic ev,
                     input logic sy, input logic [1:0] xm, input logic ins, input logic del);
    @(negedge clk);
    cgData = d; cgIsK = k; cgBad = b; cgEven = ev; syncOk = sy;
    xmitMode = xm; rmIns = ins; rmDel = del;
    @(posedge clk);
    #1;
  endtask

  task automatic chkFlags(input string tag, input logic [5:0] exp);
    logic [5:0] act;
    act = {receiving, rxDv, rxEr, rudiCfg, rudiIdle, rudiBad};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s flags actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic chkVal(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chkFlags("R1 reset", 6'b000000);
    chkVal("R1 reset cfgReg", cfgReg, 16'h0000);
    chkVal("R1 reset rxd", {8'h00, rxd}, 16'h0000);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drv(TBL[i].d, TBL[i].k, TBL[i].bad, TBL[i].ev, TBL[i].sy, TBL[i].xm, TBL[i].ins, TBL[i].del);
      checks++;
      if ({receiving, rxDv, rxEr, rudiCfg, rudiIdle, rudiBad} !== TBL[i].eFlags ||
          cfgReg !== TBL[i].eCfg) begin
        fails++;
        $display("FAIL R%0d row %0d actual=%b/%h expected=%b/%h", TBL[i].req, i,
                 {receiving, rxDv, rxEr, rudiCfg, rudiIdle, rudiBad}, cfgReg,
                 TBL[i].eFlags, TBL[i].eCfg);
      end
    end

    // R8 deletion on odd position in idle-data is invalid
    drv(8'h50, L, L, L, H, CF, L, L);
    drv(8'h77, L, L, L, H, CF, L, H);
    chkFlags("R8 odd deletion", 6'b000001);
    drv(8'hBC, H, L, H, H, CF, L, L);

    // R4 both buffer flags in tag slot: no absorption
    drv(8'hB5, L, L, L, H, CF, L, L);
    drv(8'hBC, H, L, H, H, CF, H, H);
    chkFlags("R4 both flags in tag", 6'b000001);
    drv(8'hBC, H, L, H, H, CF, L, L);

    // R6 both flags in second-data slot: invalid, word kept
    drv(8'hB5, L, L, L, H, CF, L, L);
    drv(8'h10, L, L, H, H, CF, L, L);
    drv(8'h20, L, L, L, H, CF, L, L);
    chkVal("R3 word before collision", cfgReg, 16'h2010);
    drv(8'h30, L, L, H, H, CF, H, H);
    chkFlags("R6 both flags in second data", 6'b000001);
    chkVal("R6 word kept", cfgReg, 16'h2010);
    drv(8'hBC, H, L, H, H, CF, L, L);

    // R13 packet byte path
    drv(8'h50, L, L, L, H, DT, L, L);
    drv(8'hFB, H, L, H, H, DT, L, L);
    chkVal("R13 preamble rxd", {8'h00, rxd}, 16'h0055);
    drv(8'h9E, L, L, L, H, DT, L, L);
    chkVal("R13 data rxd", {8'h00, rxd}, 16'h009E);
    drv(8'h00, L, H, H, H, DT, L, L);
    chkFlags("R13 flagged byte", 6'b111000);
    chkVal("R13 rxd held", {8'h00, rxd}, 16'h009E);

    // R2 sync loss, then bytes ignored until even comma
    drv(8'h00, L, L, L, L, DT, L, L);
    chkFlags("R2 sync loss clears", 6'b000000);
    drv(8'h42, L, L, H, H, CF, L, L);
    drv(8'hB5, L, L, L, H, CF, L, L);
    drv(8'h10, L, L, H, H, CF, L, L);
    drv(8'h20, L, L, L, H, CF, L, L);
    chkFlags("R2 hunting ignores bytes", 6'b000000);
    chkVal("R2 word untouched while hunting", cfgReg, 16'h2010);
    drv(8'hBC, H, L, H, H, CF, L, L);
    drv(8'hB5, L, L, L, H, CF, L, L);
    drv(8'h66, L, L, H, H, CF, L, L);
    drv(8'h77, L, L, L, H, CF, L, L);
    chkFlags("R2 capture resumes", 6'b000100);
    chkVal("R2 resumed word", cfgReg, 16'h7766);

    // R11 false carrier code
    drv(8'hBC, H, L, H, H, DT, L, L);
    drv(8'h50, L, L, L, H, DT, L, L);
    drv(8'h23, L, L, H, H, DT, L, L);
    chkVal("R11 false carrier rxd", {8'h00, rxd}, 16'h000E);
    chkFlags("R11 false carrier flags", 6'b101000);

    // R1 reset mid-stream
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk);
    #1;
    chkFlags("R1 reset mid-stream", 6'b000000);
    chkVal("R1 cfgReg cleared", cfgReg, 16'h0000);
    chkVal("R1 rxd cleared", {8'h00, rxd}, 16'h0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule